// File: doc/BRIEF.md
# Virtual Channel Stream Router

This block sits behind a camera-serial-link packet decoder. It receives decoded long-packet beats on one valid/ready input. Each beat carries a 2-bit virtual channel, a 6-bit data type, start and end markers and a payload word. The block copies every packet to each pixel-stream output whose settings accept it. Up to four outputs exist. All outputs share one data bus and each output has its own valid and ready. A packet that no output accepts is discarded and the input keeps flowing.

Software controls routing through a small register bank on a plain write-strobe bus with combinational read data. Each stream has a start bit, a virtual-channel filter with one admit bit per channel, and a large-buffer FIFO-mode bit. The filter can be rewritten while traffic flows. The global area holds a read-only capability word, a two-bit soft reset and an active-lane-count field. The soft-reset bits and the lane count are driven out to neighbouring logic.

Each destination set is decided on the first beat of a packet and held until its last beat. Start, stop, filter and reset changes therefore only take effect between packets.

Top module: `vc_stream_router`

## Requirements
- R1: The word at offset 0x000 is read-only and holds these fields:
  - bits [2:0]: maximum lane count minus one
  - bit 3: set when a D-PHY is present
  - bits [6:4]: number of implemented streams
  - all other bits: zero
  Writes to this word change nothing.
- R2: Offset 0x004 bit 0 drives `fe_reset` and bit 1 drives `proto_reset`. Both bits read back as written. While either bit is 1, no packet is routed to any output, and the start bits keep their stored values.
- R3: Offset 0x008 stores the active lane count in bits [11:8] and drives it on `lane_count`. All other bits of that word read as zero.
- R4: Stream n (n from 0) has its register group at (n+1)*0x100. Bit 0 at group offset 0x00 is its start bit. A packet is never routed to a stream whose start bit is 0.
- R5: Group offset 0x08 bit 31 enables filtering. Bit 16+v admits virtual channel v. With filtering on, a stream receives only packets whose channel has its admit bit set. Several channels may be admitted to one stream.
- R6: A started stream with filtering off receives every packet. One packet is copied to all streams that accept it, with sop, eop, vc, dt and payload passed through unchanged.
- R7: A packet accepted by no stream is dropped. `in_ready` stays 1 and no `out_valid` is raised.
- R8: The destination set is fixed on the sop beat. Register changes made in the middle of a packet do not alter where its remaining beats go; they apply from the next sop.
- R9: Group offset 0x0C bit 8 is the large-buffer FIFO-mode bit of that stream. It is driven on `out_large_buf[n]`.
- R10: Reads of any undefined offset, or of a stream group at or beyond NUM_STREAMS, return zero. Writes there change no state.
- R11: A beat is transferred only when every destination stream is ready. Otherwise `in_ready` is 0 and no `out_valid` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_vc | input | 2 | Virtual channel |
| in_dt | input | 6 | Data type |
| in_data | input | DW | Payload word |
| out_valid | output | NUM_STREAMS | Per-stream beat valid |
| out_ready | input | NUM_STREAMS | Per-stream ready |
| out_sop | output | 1 | Shared first-beat marker |
| out_eop | output | 1 | Shared last-beat marker |
| out_vc | output | 2 | Shared virtual channel |
| out_dt | output | 6 | Shared data type |
| out_data | output | DW | Shared payload word |
| out_large_buf | output | NUM_STREAMS | Per-stream large-buffer FIFO mode |
| lane_count | output | 4 | Active data lane count |
| fe_reset | output | 1 | Front-end soft reset |
| proto_reset | output | 1 | Protocol-layer soft reset |

## Verification
The bench builds the router with three streams, four lanes and a D-PHY present. The capability word is therefore a distinct value, 0x3B. With only three streams, group 0x400 becomes an unimplemented stream slot, which exercises the zero-read and ignored-write rule for groups beyond the implemented count. Three outputs are enough to show one channel fanned out to several streams, mixed filtered and unfiltered streams, and back-pressure from a single slow output stalling the whole copy.

// File: rtl/vc_stream_router.sv
module vc_stream_router #(
  parameter int NUM_STREAMS = 4,
  parameter int MAX_LANES   = 4,
  parameter bit HAS_DPHY    = 1'b1,
  parameter int DW          = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [11:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [1:0]             in_vc,
  input  logic [5:0]             in_dt,
  input  logic [DW-1:0]          in_data,
  output logic [NUM_STREAMS-1:0] out_valid,
  input  logic [NUM_STREAMS-1:0] out_ready,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic [1:0]             out_vc,
  output logic [5:0]             out_dt,
  output logic [DW-1:0]          out_data,
  output logic [NUM_STREAMS-1:0] out_large_buf,
  output logic [3:0]             lane_count,
  output logic                   fe_reset,
  output logic                   proto_reset
);
  localparam int NS = NUM_STREAMS;
  localparam logic [31:0] CAP_WORD =
    {25'd0, 3'(NUM_STREAMS), HAS_DPHY, 3'(MAX_LANES - 1)};

  logic [3:0] grp;
  logic [7:0] off;
  assign grp = reg_addr[11:8];
  assign off = reg_addr[7:0];

  logic [1:0] srst_q;
  logic [3:0] lanes_q;
  logic [NS-1:0] start_q, filt_q, big_q, match, route, start_eff;
  logic [NS-1:0][3:0] sel_q;
  logic in_pkt_q;
  logic [NS-1:0] held_q;
  logic acc;

  wire glob_we = reg_we && grp == 4'd0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= '0;
      lanes_q <= '0;
    end else if (glob_we) begin
      if (off == 8'h04) srst_q  <= reg_wdata[1:0];
      if (off == 8'h08) lanes_q <= reg_wdata[11:8];
    end
  end

  assign start_eff = (|srst_q) ? '0 : start_q;

  for (genvar n = 0; n < NS; n++) begin : g_str
    logic st, fe, bb;
    logic [3:0] sel;
    wire hit = reg_we && grp == 4'(n + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= 1'b0; fe <= 1'b0; bb <= 1'b0; sel <= '0;
      end else if (hit) begin
        case (off)
          8'h00: st <= reg_wdata[0];
          8'h08: begin fe <= reg_wdata[31]; sel <= reg_wdata[19:16]; end
          8'h0C: bb <= reg_wdata[8];
          default: ;
        endcase
      end
    end
    assign start_q[n] = st;
    assign filt_q[n]  = fe;
    assign big_q[n]   = bb;
    assign sel_q[n]   = sel;
    assign match[n]   = start_eff[n] & (~fe | sel[in_vc]);

    // R4
    stopped_no_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[n] && in_sop) |-> start_q[n]);
    // R5
    filter_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[n] && in_sop && filt_q[n]) |-> sel_q[n][in_vc]);
  end

  assign route    = in_sop ? match : (in_pkt_q ? held_q : '0);
  assign in_ready = &(out_ready | ~route);
  assign acc      = in_valid & in_ready;
  assign out_valid = {NS{acc}} & route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      held_q   <= '0;
    end else if (acc) begin
      if (in_sop) begin
        in_pkt_q <= !in_eop;
        held_q   <= match;
      end else if (in_eop) begin
        in_pkt_q <= 1'b0;
      end
    end
  end

  assign out_sop  = in_sop;
  assign out_eop  = in_eop;
  assign out_vc   = in_vc;
  assign out_dt   = in_dt;
  assign out_data = in_data;
  assign out_large_buf = big_q;
  assign lane_count    = lanes_q;
  assign fe_reset      = srst_q[0];
  assign proto_reset   = srst_q[1];

  always_comb begin
    reg_rdata = '0;
    if (grp == 4'd0) begin
      case (off)
        8'h00: reg_rdata = CAP_WORD;
        8'h04: reg_rdata = {30'd0, srst_q};
        8'h08: reg_rdata = {20'd0, lanes_q, 8'd0};
        default: ;
      endcase
    end
    for (int n = 0; n < NS; n++) begin
      if (grp == 4'(n + 1)) begin
        case (off)
          8'h00: reg_rdata = {31'd0, start_q[n]};
          8'h08: reg_rdata = {filt_q[n], 11'd0, sel_q[n], 16'd0};
          8'h0C: reg_rdata = {23'd0, big_q[n], 8'd0};
          default: ;
        endcase
      end
    end
  end

  // R8
  held_route_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && !(acc && (in_sop || in_eop))) |=> $stable(held_q));
  // R2
  srst_blocks_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|srst_q && in_sop) |-> out_valid == '0);
  // R10
  unimpl_group_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(grp) > NUM_STREAMS) |-> reg_rdata == 32'd0);
endmodule

// File: tb/vc_stream_router_tb_top.sv
module vc_stream_router_tb_top;
  localparam int NS = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0, in_ready, in_sop = 1'b0, in_eop = 1'b0;
  logic [1:0] in_vc = '0;
  logic [5:0] in_dt = '0;
  logic [31:0] in_data = '0;
  logic [NS-1:0] out_valid, out_large_buf;
  logic [NS-1:0] out_ready = '1;
  logic out_sop, out_eop, fe_reset, proto_reset;
  logic [1:0] out_vc;
  logic [5:0] out_dt;
  logic [31:0] out_data;
  logic [3:0] lane_count;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  vc_stream_router #(.NUM_STREAMS(NS), .MAX_LANES(4), .HAS_DPHY(1'b1), .DW(32)) dut_i (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .in_valid, .in_ready, .in_sop, .in_eop, .in_vc, .in_dt, .in_data,
    .out_valid, .out_ready, .out_sop, .out_eop, .out_vc, .out_dt, .out_data,
    .out_large_buf, .lane_count, .fe_reset, .proto_reset);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic beat(logic s, logic e, logic [1:0] vc, logic [31:0] d,
                      output logic [NS-1:0] m, output logic r);
    @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_eop = e; in_vc = vc; in_dt = 6'h2A; in_data = d;
    #1 m = out_valid; r = in_ready;
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic pkt(logic [1:0] vc, int n, logic [NS-1:0] exp, string req);
    logic [NS-1:0] m; logic r;
    for (int i = 0; i < n; i++) begin
      beat(i == 0, i == n - 1, vc, 32'hA000 + i, m, r);
      chk({req, " mask"}, 32'(m), 32'(exp));
      chk({req, " ready"}, 32'(r), 32'd1);
    end
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h100, d); chk("R4 reset start", d, 0);
    chk("R3 reset lanes", 32'(lane_count), 0);
    pkt(2'd0, 2, 3'b000, "R7 reset drop");
  endtask

  task automatic t_cap();
    logic [31:0] d;
    rd(12'h000, d); chk("R1 cap", d, 32'h3B);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); chk("R1 cap ro", d, 32'h3B);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R3 lane field", d, 32'h0000_0F00);
    wr(12'h008, 32'h0000_0200);
    chk("R3 lane_count", 32'(lane_count), 2);
  endtask

  task automatic t_nofilter();
    logic [NS-1:0] m; logic r;
    wr(12'h100, 1); wr(12'h300, 1);
    beat(1'b1, 1'b1, 2'd2, 32'hDEAD_BEEF, m, r);
    chk("R6 fanout", 32'(m), 32'b101);
    chk("R6 data", out_data, 32'hDEAD_BEEF);
    chk("R6 vc/dt", {out_vc, out_dt, out_sop, out_eop}, {2'd2, 6'h2A, 1'b1, 1'b1});
    idle();
  endtask

  task automatic t_filter();
    wr(12'h108, 32'h800A_0000);
    wr(12'h208, 32'h8002_0000); wr(12'h200, 1);
    pkt(2'd1, 3, 3'b111, "R5 vc1");
    pkt(2'd3, 2, 3'b101, "R5 vc3");
    pkt(2'd0, 1, 3'b100, "R5 vc0");
  endtask

  task automatic t_drop();
    logic [31:0] d;
    wr(12'h300, 0);
    rd(12'h300, d); chk("R4 stop readback", d, 0);
    pkt(2'd0, 3, 3'b000, "R7 unmatched");
  endtask

  task automatic t_boundary();
    logic [NS-1:0] m; logic r;
    beat(1'b1, 1'b0, 2'd1, 1, m, r); chk("R8 sop", 32'(m), 32'b011);
    idle();
    wr(12'h300, 1); wr(12'h100, 0); wr(12'h208, 0);
    beat(1'b0, 1'b0, 2'd1, 2, m, r); chk("R8 mid", 32'(m), 32'b011);
    beat(1'b0, 1'b1, 2'd1, 3, m, r); chk("R8 eop", 32'(m), 32'b011);
    idle();
    pkt(2'd1, 2, 3'b110, "R8 next pkt");
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(12'h004, 3);
    rd(12'h004, d); chk("R2 readback", d, 3);
    chk("R2 outs", {30'd0, proto_reset, fe_reset}, 3);
    pkt(2'd1, 2, 3'b000, "R2 held stop");
    rd(12'h200, d); chk("R2 start kept", d, 1);
    wr(12'h004, 1);
    pkt(2'd1, 1, 3'b000, "R2 fe only");
    wr(12'h004, 0);
    chk("R2 released", {30'd0, proto_reset, fe_reset}, 0);
    pkt(2'd1, 1, 3'b110, "R2 after release");
  endtask

  task automatic t_bigbuf();
    logic [31:0] d;
    wr(12'h20C, 32'h0000_0100);
    rd(12'h20C, d); chk("R9 readback", d, 32'h100);
    chk("R9 pin", 32'(out_large_buf), 32'b010);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    wr(12'h400, 1); wr(12'h40C, 32'h100); wr(12'h104, 1); wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h400, d); chk("R10 grp3", d, 0);
    rd(12'h40C, d); chk("R10 grp3 cfg", d, 0);
    rd(12'h104, d); chk("R10 hole", d, 0);
    rd(12'h010, d); chk("R10 global hole", d, 0);
    rd(12'h100, d); chk("R10 no side effect", d, 0);
    chk("R10 bigbuf intact", 32'(out_large_buf), 32'b010);
    pkt(2'd1, 1, 3'b110, "R10 routing intact");
  endtask

  task automatic t_bp();
    logic [NS-1:0] m; logic r;
    out_ready = 3'b101;
    beat(1'b1, 1'b0, 2'd1, 7, m, r);
    chk("R11 stall ready", 32'(r), 0);
    chk("R11 stall valid", 32'(m), 0);
    @(negedge clk); #1;
    chk("R11 still stalled", 32'(in_ready), 0);
    out_ready = 3'b111; #1;
    chk("R11 release valid", 32'(out_valid), 32'b110);
    chk("R11 release ready", 32'(in_ready), 1);
    beat(1'b0, 1'b1, 2'd1, 8, m, r);
    chk("R11 eop", 32'(m), 32'b110);
    idle();
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_cap(); t_lanes(); t_nofilter(); t_filter(); t_drop();
    t_boundary(); t_srst(); t_bigbuf(); t_unimpl(); t_bp();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule